// File: doc/BRIEF.md
# Two-Rank Byte-Loadable Angle Register

This block holds the 16-bit binary angle word that drives a digital-to-synchro/resolver conversion stage. It has two ranks. The first rank is a pair of byte registers: one for the upper half of the word and one for the lower half. Each has its own enable. The second rank is the full word that the converter reads. A separate transfer enable copies both first-rank bytes into it in a single step. A host on a 16-bit bus can raise all three enables together, and the data then passes straight through. A host on an 8-bit bus loads the upper byte, then the lower byte, then pulses the transfer enable. The converter therefore never sees a word that is half old and half new.

Each enable is level-sensitive. While it is high the stage follows its input, and while it is low the stage holds. Everything is sampled on a system clock, and the output changes at the edge that samples the enables. A timing monitor measures each enable pulse and the stability of the data bus in clock cycles. It raises a sticky error flag when a pulse is too short or when the data changed too close to the end of a pulse. An enable that a system does not use is tied high, which makes that stage transparent.

Top module: `dual_rank_angle_reg`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `angle` is 0 and `timing_err` is 0. Both first-rank bytes are also cleared to 0.
- R2: At an edge where `en_hi` is 1, the upper first-rank byte loads `din[15:8]` when `byte_mode` is 0, and loads `din[7:0]` when `byte_mode` is 1.
- R3: At an edge where `en_lo` is 1, the lower first-rank byte loads `din[7:0]` in both modes.
- R4: A first-rank byte whose enable is 0 keeps its value whatever `din` and `byte_mode` do.
- R5: At an edge where `en_xfer` is 1, `angle` becomes {upper byte, lower byte}. While `en_xfer` is 0, `angle` holds all 16 bits, so byte loads never show a half-updated word.
- R6: When a byte enable and `en_xfer` are both 1 at the same edge, the new byte reaches `angle` at that edge. With all three enables high and `byte_mode`=0, `angle` equals the `din` sampled at the previous edge. With all three enables high and `byte_mode`=1, `angle` is that sample's low byte repeated in both halves.
- R7: When an enable falls after being high for fewer than MIN_PULSE (default 2) consecutive edges, `timing_err` becomes 1 at that falling edge.
- R8: Suppose an enable falls. If the `din` value sampled at the last edge where it was high had not also been present at the SETUP (default 1) edges before, `timing_err` becomes 1.
- R9: Once `timing_err` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_mode | input | 1 | 1: both bytes load from din[7:0]; 0: 16-bit bus |
| din | input | 16 | Angle data bus, bit 15 is the MSB |
| en_hi | input | 1 | Upper first-rank byte enable, transparent when 1 |
| en_lo | input | 1 | Lower first-rank byte enable, transparent when 1 |
| en_xfer | input | 1 | Second-rank word enable, transparent when 1 |
| angle | output | 16 | Word presented to the converter |
| timing_err | output | 1 | Sticky pulse-width or setup violation flag |

## Verification
The bench loads bytes one at a time with the transfer enable low, and compares the output on every cycle. A design that leaked a byte into the second rank early would show a mixed word here. It also raises a byte enable together with the transfer enable, to catch a design that transfers the stale first-rank value instead of letting the new byte flow through. In 8-bit mode it checks which bus lanes each half takes, so swapped lanes show up. It also produces a one-cycle pulse and a data change on the last high cycle of a pulse, each of which must set the flag, and then checks that later clean pulses leave the flag set.

// File: rtl/dual_rank_angle_reg.sv
module dual_rank_angle_reg #(
  parameter int WORD      = 16,
  parameter int MIN_PULSE = 2,
  parameter int SETUP     = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_mode,
  input  logic [WORD-1:0] din,
  input  logic            en_hi,
  input  logic            en_lo,
  input  logic            en_xfer,
  output logic [WORD-1:0] angle,
  output logic            timing_err
);
  localparam int HALF = WORD / 2;
  localparam int NEN  = 3;
  localparam int PW   = $clog2(MIN_PULSE + 2);
  localparam int SW   = $clog2(SETUP + 2);

  logic [HALF-1:0] hi_q, lo_q, hi_in, hi_nx, lo_nx;
  logic [WORD-1:0] word_q;

  assign hi_in = byte_mode ? din[HALF-1:0] : din[WORD-1:HALF];
  assign hi_nx = en_hi ? hi_in : hi_q;
  assign lo_nx = en_lo ? din[HALF-1:0] : lo_q;
  assign angle = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      word_q <= '0;
    end else begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
      if (en_xfer) word_q <= {hi_nx, lo_nx};
    end
  end

  logic [NEN-1:0]  en_v, en_q, fell;
  logic [PW-1:0]   cnt_q [NEN];
  logic [WORD-1:0] din_q;
  logic [SW-1:0]   stab_q, stab_cur;
  logic            viol;

  assign en_v = {en_xfer, en_lo, en_hi};
  assign fell = en_q & ~en_v;

  always_comb begin
    if (din != din_q)               stab_cur = '0;
    else if (stab_q >= SW'(SETUP))  stab_cur = stab_q;
    else                            stab_cur = stab_q + 1'b1;
  end

  always_comb begin
    viol = 1'b0;
    for (int i = 0; i < NEN; i++)
      if (fell[i] && (cnt_q[i] < PW'(MIN_PULSE) || stab_q < SW'(SETUP)))
        viol = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      din_q      <= '0;
      stab_q     <= '0;
      timing_err <= 1'b0;
      for (int i = 0; i < NEN; i++) cnt_q[i] <= '0;
    end else begin
      en_q       <= en_v;
      din_q      <= din;
      stab_q     <= stab_cur;
      timing_err <= timing_err | viol;
      for (int i = 0; i < NEN; i++)
        if (!en_v[i])                        cnt_q[i] <= '0;
        else if (cnt_q[i] < PW'(MIN_PULSE))  cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  // R5: a low transfer enable freezes the whole output word
  a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !en_xfer |=> $stable(angle));

  // R6: full flow-through on a 16-bit bus
  a_r6_flow_16: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi && en_lo && en_xfer && !byte_mode) |=> angle == $past(din));

  // R6: full flow-through on an 8-bit bus
  a_r6_flow_8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hi && en_lo && en_xfer && byte_mode) |=> angle == {2{$past(din[HALF-1:0])}});

  // R9: the error flag never clears outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err);

  // R7: a short pulse on any enable is flagged
  generate
    for (genvar g = 0; g < NEN; g++) begin : g_pw_chk
      a_r7_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[g] && !en_v[g] && cnt_q[g] < PW'(MIN_PULSE)) |=> timing_err);
    end
  endgenerate
endmodule

// File: tb/dual_rank_angle_reg_tb.sv
module dual_rank_angle_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic [15:0] din = '0;
  logic        en_hi = 1'b0, en_lo = 1'b0, en_xfer = 1'b0;
  logic [15:0] angle;
  logic        timing_err;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dual_rank_angle_reg dut_i (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .din(din),
    .en_hi(en_hi), .en_lo(en_lo), .en_xfer(en_xfer),
    .angle(angle), .timing_err(timing_err)
  );

  // {byte_mode, en_hi, en_lo, en_xfer, din, expected angle}
  localparam logic [35:0] VEC [11] = '{
    {4'b0111, 16'h1234, 16'h1234},
    {4'b0111, 16'hA5C3, 16'hA5C3},
    {4'b0110, 16'h0F0F, 16'hA5C3},
    {4'b0001, 16'hFFFF, 16'h0F0F},
    {4'b1100, 16'h007E, 16'h0F0F},
    {4'b1010, 16'h0081, 16'h0F0F},
    {4'b1001, 16'h0000, 16'h7E81},
    {4'b1101, 16'h1234, 16'h3481},
    {4'b0011, 16'hBEEF, 16'h34EF},
    {4'b0000, 16'h5555, 16'h34EF},
    {4'b1111, 16'hABCD, 16'hCDCD}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic h, input logic l, input logic x,
                       input logic [15:0] d);
    @(negedge clk);
    byte_mode = m; en_hi = h; en_lo = l; en_xfer = x; din = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_hi = 0; en_lo = 0; en_xfer = 0; din = '0; byte_mode = 0;
    @(negedge clk);
    chk("R1 angle in reset", {16'h0, angle}, 32'h0);
    chk("R1 err in reset", {31'h0, timing_err}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] prev;
    repeat (2) @(negedge clk);
    chk("R1 angle at reset", {16'h0, angle}, 32'h0);
    chk("R1 err at reset", {31'h0, timing_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 angle after release", {16'h0, angle}, 32'h0);
    prev = 16'h0;

    // R2 R3 R4 R5 R6: vector walk, each row held three cycles
    for (int r = 0; r < 11; r++) begin
      int mixed = 0;
      byte_mode = VEC[r][35]; en_hi = VEC[r][34]; en_lo = VEC[r][33];
      en_xfer = VEC[r][32]; din = VEC[r][31:16];
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (angle !== prev && angle !== VEC[r][15:0]) mixed++;
      end
      chk($sformatf("R5 no partial word row %0d", r), mixed, 0);
      chk($sformatf("R2 R3 R4 R6 row %0d", r), {16'h0, angle}, {16'h0, VEC[r][15:0]});
      prev = VEC[r][15:0];
    end
    chk("R7 R8 clean traffic leaves err low", {31'h0, timing_err}, 32'h0);

    // R7: one-cycle pulse on the upper byte enable
    drive(1, 0, 0, 0, 16'h0011);
    drive(1, 1, 0, 0, 16'h0011);
    drive(1, 0, 0, 0, 16'h0011);
    @(negedge clk);
    chk("R7 short pulse flagged", {31'h0, timing_err}, 32'h1);
    chk("R4 angle untouched without transfer", {16'h0, angle}, 32'h0000CDCD);

    // R9: clean pulses afterwards keep the flag
    drive(1, 0, 0, 1, 16'h0011);
    drive(1, 0, 0, 1, 16'h0011);
    drive(1, 0, 0, 1, 16'h0011);
    drive(1, 0, 0, 0, 16'h0011);
    repeat (2) @(negedge clk);
    chk("R9 flag sticky", {31'h0, timing_err}, 32'h1);
    chk("R2 8-bit lane to upper byte", {16'h0, angle}, 32'h000011CD);

    do_reset();
    @(negedge clk);
    chk("R1 clear after reset", {16'h0, angle}, 32'h0);

    // R8: data changes on the last high cycle of a pulse
    drive(0, 0, 1, 0, 16'h0000);
    drive(0, 0, 1, 0, 16'h0000);
    drive(0, 0, 1, 0, 16'h0099);
    drive(0, 0, 0, 0, 16'h0099);
    @(negedge clk);
    chk("R8 setup violation flagged", {31'h0, timing_err}, 32'h1);
    drive(0, 0, 0, 1, 16'h0099);
    drive(0, 0, 0, 1, 16'h0099);
    drive(0, 0, 0, 0, 16'h0099);
    @(negedge clk);
    chk("R3 lower byte captured", {16'h0, angle}, 32'h00000099);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule